// File: doc/BRIEF.md
# Self Refresh Rate Selector

This block sets the pace of internal refresh requests for a DRAM device model while the device is in self refresh. It watches the case temperature and two mode enables. The first enable forces the doubled rate. The second lets the rate follow temperature. From these it issues one-cycle refresh requests, either at the normal (1X) interval or at half that interval (2X). The refresh operation itself is handled by another block.

The normal operating limit is 85 °C, and the extended range reaches 95 °C. With neither enable set, the rate stays at 1X. Using the extended range is then the system's responsibility. With the forced enable set, the rate is 2X at any temperature. With the temperature-following enable set, the block moves to 2X at a threshold that never exceeds 85 °C. It returns to 1X only once the temperature has dropped a hysteresis band below that threshold. The two enables may not be set together. If they are, the block flags a configuration error and refreshes at 2X, the safe rate. A rate change waits for the end of the interval in progress, so no interval is ever cut short or stretched.

Top module: `selfref_rate_sel`

## Requirements
- R1: After reset, `refresh_req`, `rate_2x` and `cfg_err` are all 0.
- R2: While `sr_active` is 0, no request is issued and the interval count is held at zero. The first request comes exactly one interval (at the rate then selected) after the first clock edge that samples `sr_active` high.
- R3: With neither enable set, requests are spaced PERIOD_1X cycles apart and `rate_2x` is 0, even at case temperatures above 85 °C.
- R4: With only `force_2x_en` set, requests are spaced PERIOD_1X/2 cycles apart and `rate_2x` is 1, at any temperature.
- R5: With only `auto_en` set and self refresh active, the 2X rate is chosen once `case_temp` (unsigned, in °C) is at or above min(UP_THRESH_C, 85). The 1X rate is chosen again once `case_temp` is at or below that threshold minus HYST_C. Between those two values the previous choice is kept.
- R6: While self refresh is active, a rate change takes effect only at an interval boundary. The interval in progress completes at its old length, and `rate_2x` changes only in the same cycle as a request.
- R7: When both enables are set, `cfg_err` is 1 from the next cycle, and the 2X rate is selected. `cfg_err` clears one cycle after either enable is cleared.
- R8: While `sr_active` is 0, `rate_2x` shows the selected rate one cycle after the enables change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| case_temp | input | TEMP_W | Case temperature in whole °C, unsigned |
| sr_active | input | 1 | Device is in self refresh |
| force_2x_en | input | 1 | Mode enable: always use the 2X rate |
| auto_en | input | 1 | Mode enable: temperature-following rate |
| refresh_req | output | 1 | One-cycle refresh request pulse |
| rate_2x | output | 1 | Rate in use: 1 = 2X, 0 = 1X |
| cfg_err | output | 1 | Both mode enables set (illegal) |

## Verification
The assertions assume that `sr_active` and both enables are synchronous to `clk`, and that they hold their reset values until the internal reset has been released. They also assume that PERIOD_1X is even and at least 4, so that requests can never fall on adjacent cycles. The bench meets these conditions by driving every input on the falling edge, by holding all inputs at 0 through reset and for several cycles after it, and by using the default even period. The bench changes temperature and enables only on the falling edge of a request cycle, so each measured interval can be credited to exactly one rate.

// File: rtl/selfref_pkg.sv
package selfref_pkg;

  typedef enum logic {
    RATE_1X = 1'b0,
    RATE_2X = 1'b1
  } rate_e;

  // Case temperature above which the doubled rate is mandatory.
  localparam int NORMAL_LIMIT_C = 85;

endpackage

// File: rtl/selfref_cfg_check.sv
module selfref_cfg_check
  import selfref_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  force_2x_en,
  input  logic  auto_en,
  input  logic  hot,
  output rate_e sel_rate,
  output logic  cfg_err
);

  logic both_set;
  logic err_d, err_q;

  assign both_set = force_2x_en & auto_en;

  // Rate choice: an illegal setting and the forced mode both pick 2X.
  always_comb begin
    if (both_set || force_2x_en) begin
      sel_rate = RATE_2X;
    end else if (auto_en && hot) begin
      sel_rate = RATE_2X;
    end else begin
      sel_rate = RATE_1X;
    end
  end

  always_comb begin
    err_d = both_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/selfref_auto_track.sv
module selfref_auto_track #(
  parameter int TEMP_W      = 8,
  parameter int UP_THRESH_C = 85,
  parameter int HYST_C      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] case_temp,
  input  logic              auto_en,
  input  logic              sr_active,
  output logic              hot
);

  // The switch-up point is capped at the normal limit.
  localparam int UP_EFF  = (UP_THRESH_C < selfref_pkg::NORMAL_LIMIT_C) ?
                           UP_THRESH_C : selfref_pkg::NORMAL_LIMIT_C;
  localparam int DOWN_AT = (UP_EFF > HYST_C) ? (UP_EFF - HYST_C) : 0;
  localparam logic [TEMP_W-1:0] UP_T   = TEMP_W'(UP_EFF);
  localparam logic [TEMP_W-1:0] DOWN_T = TEMP_W'(DOWN_AT);

  logic hot_d, hot_q;
  logic upd_en;

  assign upd_en = auto_en & sr_active;

  always_comb begin
    hot_d = hot_q;
    if (!auto_en) begin
      hot_d = 1'b0;
    end else if (upd_en) begin
      if (case_temp >= UP_T) begin
        hot_d = 1'b1;
      end else if (case_temp <= DOWN_T) begin
        hot_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= 1'b0;
    end else begin
      hot_q <= hot_d;
    end
  end

  assign hot = hot_q;

endmodule

// File: rtl/selfref_interval_ctr.sv
module selfref_interval_ctr
  import selfref_pkg::*;
#(
  parameter int PERIOD_1X = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e sel_rate,
  output logic  pulse,
  output rate_e cur_rate
);

  localparam int PERIOD_2X = PERIOD_1X / 2;
  localparam int CNT_W     = $clog2(PERIOD_1X);
  localparam logic [CNT_W-1:0] LAST_1X = CNT_W'(PERIOD_1X - 1);
  localparam logic [CNT_W-1:0] LAST_2X = CNT_W'(PERIOD_2X - 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             pulse_d, pulse_q;
  rate_e            rate_d, rate_q;
  logic             at_end;

  assign at_end = (rate_q == RATE_2X) ? (cnt_q == LAST_2X) : (cnt_q == LAST_1X);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    rate_d  = rate_q;
    if (!run) begin
      cnt_d  = '0;
      rate_d = sel_rate;
    end else if (at_end) begin
      cnt_d   = '0;
      pulse_d = 1'b1;
      rate_d  = sel_rate;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      rate_q  <= RATE_1X;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      rate_q  <= rate_d;
    end
  end

  assign pulse    = pulse_q;
  assign cur_rate = rate_q;

endmodule

// File: rtl/selfref_rate_sel.sv
module selfref_rate_sel
  import selfref_pkg::*;
#(
  parameter int PERIOD_1X   = 64,
  parameter int TEMP_W      = 8,
  parameter int UP_THRESH_C = 85,
  parameter int HYST_C      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] case_temp,
  input  logic              sr_active,
  input  logic              force_2x_en,
  input  logic              auto_en,
  output logic              refresh_req,
  output logic              rate_2x,
  output logic              cfg_err
);

  logic  rst_meta, rst_n_sync;
  logic  hot;
  rate_e sel_rate;
  rate_e cur_rate;

  // Reset asserts at once and is released two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  selfref_auto_track #(
    .TEMP_W      (TEMP_W),
    .UP_THRESH_C (UP_THRESH_C),
    .HYST_C      (HYST_C)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .case_temp (case_temp),
    .auto_en   (auto_en),
    .sr_active (sr_active),
    .hot       (hot)
  );

  selfref_cfg_check u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .force_2x_en (force_2x_en),
    .auto_en     (auto_en),
    .hot         (hot),
    .sel_rate    (sel_rate),
    .cfg_err     (cfg_err)
  );

  selfref_interval_ctr #(
    .PERIOD_1X (PERIOD_1X)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .run      (sr_active),
    .sel_rate (sel_rate),
    .pulse    (refresh_req),
    .cur_rate (cur_rate)
  );

  assign rate_2x = (cur_rate == RATE_2X);

endmodule

// File: rtl/selfref_rate_sel_chk.sv
module selfref_rate_sel_chk #(
  parameter int PERIOD_1X = 64
) (
  input logic clk,
  input logic rst_n,
  input logic sr_active,
  input logic force_2x_en,
  input logic auto_en,
  input logic refresh_req,
  input logic rate_2x,
  input logic cfg_err
);

  localparam int GW = $clog2(PERIOD_1X + 2);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (!sr_active || refresh_req) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sr_active) |-> !refresh_req);

  // R3
  max_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_q) <= PERIOD_1X);

  // R6
  rate_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sr_active) && !refresh_req) |-> $stable(rate_2x));

  // R6
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  // R7
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_2x_en && auto_en) |-> cfg_err);

  // R8
  idle_force_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sr_active && force_2x_en) |-> rate_2x);

endmodule

bind selfref_rate_sel selfref_rate_sel_chk #(.PERIOD_1X(PERIOD_1X)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .sr_active   (sr_active),
  .force_2x_en (force_2x_en),
  .auto_en     (auto_en),
  .refresh_req (refresh_req),
  .rate_2x     (rate_2x),
  .cfg_err     (cfg_err)
);

// File: tb/selfref_rate_sel_bench.sv
`timescale 1ns/1ps
module selfref_rate_sel_bench;

  localparam int P1 = 64;
  localparam int P2 = P1 / 2;

  logic       clk;
  logic       rst_n;
  logic [7:0] case_temp;
  logic       sr_active;
  logic       force_2x_en;
  logic       auto_en;
  logic       refresh_req;
  logic       rate_2x;
  logic       cfg_err;

  int n_run;
  int n_fail;
  bit done;

  selfref_rate_sel #(.PERIOD_1X(P1)) u_selfref_rate_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .case_temp   (case_temp),
    .sr_active   (sr_active),
    .force_2x_en (force_2x_en),
    .auto_en     (auto_en),
    .refresh_req (refresh_req),
    .rate_2x     (rate_2x),
    .cfg_err     (cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts falling edges from the current one until refresh_req is seen high.
  task automatic next_gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!refresh_req && n < 400);
  endtask

  task automatic go_idle();
    sr_active = 1'b0;
    force_2x_en = 1'b0;
    auto_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(refresh_req == 1'b0, "R1 refresh_req", int'(refresh_req), 0);
    chk(rate_2x == 1'b0, "R1 rate_2x", int'(rate_2x), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_idle();
    int seen;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (refresh_req) seen++;
    end
    chk(seen == 0, "R2 no request when idle", seen, 0);
  endtask

  task automatic t_plain_hot();
    int g;
    case_temp = 8'd95;
    @(negedge clk);
    sr_active = 1'b1;
    next_gap(g);
    chk(g == P1, "R2 first gap", g, P1);
    next_gap(g);
    chk(g == P1, "R3 1X gap at 95C", g, P1);
    chk(rate_2x == 1'b0, "R3 rate_2x", int'(rate_2x), 0);
    go_idle();
  endtask

  task automatic t_force();
    int g;
    case_temp = 8'd30;
    force_2x_en = 1'b1;
    @(negedge clk);
    sr_active = 1'b1;
    next_gap(g);
    chk(g == P2, "R4 first 2X gap", g, P2);
    next_gap(g);
    chk(g == P2, "R4 2X gap at 30C", g, P2);
    chk(rate_2x == 1'b1, "R4 rate_2x", int'(rate_2x), 1);
    go_idle();
  endtask

  task automatic t_boundary();
    int g;
    case_temp = 8'd40;
    @(negedge clk);
    sr_active = 1'b1;
    next_gap(g);
    repeat (10) @(negedge clk);
    force_2x_en = 1'b1;
    @(negedge clk);
    chk(rate_2x == 1'b0, "R6 rate held mid interval", int'(rate_2x), 0);
    next_gap(g);
    g = g + 11;
    chk(g == P1, "R6 old interval completes", g, P1);
    chk(rate_2x == 1'b1, "R6 rate switches with request", int'(rate_2x), 1);
    next_gap(g);
    chk(g == P2, "R6 new interval 2X", g, P2);
    go_idle();
  endtask

  task automatic t_auto();
    int g;
    case_temp = 8'd70;
    auto_en = 1'b1;
    @(negedge clk);
    sr_active = 1'b1;
    next_gap(g);
    chk(g == P1, "R5 1X at 70C", g, P1);
    case_temp = 8'd85;
    next_gap(g);
    chk(g == P1, "R5 interval before switch", g, P1);
    chk(rate_2x == 1'b1, "R5 2X at 85C threshold", int'(rate_2x), 1);
    next_gap(g);
    chk(g == P2, "R5 2X gap", g, P2);
    case_temp = 8'd83;
    next_gap(g);
    chk(g == P2 && rate_2x, "R5 hold 2X at 83C", g, P2);
    case_temp = 8'd82;
    next_gap(g);
    chk(g == P2, "R5 last 2X interval", g, P2);
    chk(rate_2x == 1'b0, "R5 back to 1X at 82C", int'(rate_2x), 0);
    next_gap(g);
    chk(g == P1, "R5 1X gap again", g, P1);
    go_idle();
  endtask

  task automatic t_both();
    int g;
    case_temp = 8'd40;
    force_2x_en = 1'b1;
    auto_en = 1'b1;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R7 cfg_err set", int'(cfg_err), 1);
    chk(rate_2x == 1'b1, "R7 safe rate 2X", int'(rate_2x), 1);
    sr_active = 1'b1;
    next_gap(g);
    chk(g == P2, "R7 2X gap with both set", g, P2);
    auto_en = 1'b0;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R7 cfg_err clears", int'(cfg_err), 0);
    go_idle();
  endtask

  task automatic t_idle_rate();
    force_2x_en = 1'b1;
    @(negedge clk);
    chk(rate_2x == 1'b1, "R8 idle rate follows force on", int'(rate_2x), 1);
    force_2x_en = 1'b0;
    @(negedge clk);
    chk(rate_2x == 1'b0, "R8 idle rate follows force off", int'(rate_2x), 0);
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    case_temp = 8'd25;
    sr_active = 1'b0;
    force_2x_en = 1'b0;
    auto_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_idle();
    t_plain_hot();
    t_force();
    t_boundary();
    t_auto();
    t_both();
    t_idle_rate();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule